// File: doc/BRIEF.md
# Multi-channel external interrupt detector

This block watches sixteen asynchronous input pins and turns selected activity on each of them into an interrupt request. Every pin is brought into the clock domain by a two-stage synchroniser and then passes through a glitch filter, so the filtered level changes only after the synchronised input has held a new value for a fixed number of clocks. A per-channel trigger detector then watches the filtered level for either a level condition or a transition, according to a 2-bit code that software programs.

A detected event sets a sticky request flag for its channel. The flag stays set until software writes zero to its bit. Channels are grouped into two banks of eight. Each bank has an 8-bit enable register, an 8-bit flag register and a 16-bit trigger-select register, all reached over a simple single-cycle write bus with a combinational read port. Each bank drives one interrupt line, which is high while any channel of that bank has both its flag and its enable bit set. Flags still record events on masked channels, so software can poll them.

Top module: `ext_irq_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every register clears, so all register reads return 0 and irq_out is 0.
- R2: Register map: bus_addr[2] selects the bank (0 holds channels 0-7, 1 holds channels 8-15), and bus_addr[1:0] selects 0 = enable, 1 = flag, 2 = trigger select, 3 = reads zero. In the enable and flag registers, bit i belongs to channel bank*8+i and bits 15:8 read 0. In the trigger-select register, bits [2i+1:2i] hold channel i's code. Enable and trigger-select registers read back what was written.
- R3: Trigger code 2'b10 sets the flag once when the filtered input goes from 0 to 1. Code 2'b11 sets it once when the filtered input goes from 1 to 0. A transition in the other direction sets nothing.
- R4: Trigger code 2'b00 sets the flag on every clock that the filtered input is 0, and code 2'b01 on every clock that it is 1. A clear therefore does not hold while the level is still present.
- R5: The synchronised input must hold a new value for 3 consecutive clocks before the filtered level follows it. A pulse of 2 clocks causes no event. A pulse of 3 clocks is detected. After a clean change, the flag is set within 8 clock cycles.
- R6: A set flag stays set until a write of 0 to its bit in its bank's flag register. That write clears it when no new event arrives in the same cycle.
- R7: Writing 1 to a flag bit has no effect. When a clear and a new event for the same channel fall in the same cycle, the flag stays set.
- R8: Flags are set whatever the enable bits hold. irq_out[b] is high exactly when some channel of bank b has both its flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Asynchronous external interrupt pins, one per channel |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 3 | Register address: bank in bit 2, register select in bits 1:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_out | output | 2 | Interrupt request per bank |

## Verification
The bench walks all four trigger codes in both banks. For each code it uses start and end levels chosen so that an edge trigger with its direction swapped, or a level trigger with its polarity swapped, would leave a flag the wrong way round. It sends 2-clock and 3-clock pulses into the filter: a filter that is one stage too short would flag the short pulse, and one that is too long would miss the 3-clock pulse. It clears a flag while a level is still active, to catch a design in which the clear wins over the event, and it writes ones to the flag register, which would set flags if such a write were taken as a set. Finally it raises a flag on a masked channel and then enables that channel, exposing any design that gates the flag itself rather than only the interrupt line, or that routes a channel to the wrong bank's line.

// File: rtl/extint_pkg.sv
// Shared encodings for the external interrupt detector.
// Assumes: 2-bit trigger codes and 2-bit register selects as listed in the brief.
package extint_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    localparam logic [1:0] REG_ENABLE = 2'd0;
    localparam logic [1:0] REG_FLAG   = 2'd1;
    localparam logic [1:0] REG_DETECT = 2'd2;

endpackage

// File: rtl/irq_pin_filter.sv
// Brings one asynchronous pin into the clock domain and removes glitches.
// The filtered level changes only after the synchronised value has held
// for FILT_LEN consecutive clocks. Also gives the filtered level of the
// previous clock, which the edge detector compares against.
// Assumes: FILT_LEN >= 1; reset sets every stage to 0.
module irq_pin_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic filt_o,
    output logic filt_prev_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                all_hi;
    logic                all_lo;

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], pin_i};
    end

    generate
        if (FILT_LEN == 1) begin : g_hist_one
            // Single-entry history of the synchronised value.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= sync_q[1];
            end
        end else begin : g_hist_shift
            // History shift register of the synchronised value.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            end
        end
    endgenerate

    assign all_hi = &hist_q;
    assign all_lo = ~|hist_q;

    // Filtered level follows the history only when every sample agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o      <= 1'b0;
            filt_prev_o <= 1'b0;
        end else begin
            filt_prev_o <= filt_o;
            if (all_hi)      filt_o <= 1'b1;
            else if (all_lo) filt_o <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_trigger.sv
// Decides, for one channel, whether the filtered input shows the event its
// trigger code selects: an active level on this clock, or a transition
// between the previous clock and this one.
// Assumes: filt_i and filt_prev_i come from irq_pin_filter.
module irq_trigger
    import extint_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       filt_i,
    input  logic       filt_prev_i,
    output logic       event_o
);

    // Event decode per trigger code.
    always_comb begin
        unique case (trig_e'(mode_i))
            TRIG_LOW:  event_o = ~filt_i;
            TRIG_HIGH: event_o =  filt_i;
            TRIG_RISE: event_o =  filt_i & ~filt_prev_i;
            TRIG_FALL: event_o = ~filt_i &  filt_prev_i;
            default:   event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_regfile.sv
// Software-visible state for all banks: enable, sticky flag and trigger
// select registers. Also drives the per-bank interrupt lines and the
// combinational read port.
// Assumes: one write per cycle; addr[1:0] selects the register and the upper
// address bits select the bank; unmapped addresses read zero.
module irq_regfile
    import extint_pkg::*;
#(
    parameter int unsigned CH_PER_BANK = 8,
    parameter int unsigned NUM_BANKS   = 2,
    localparam int unsigned NUM_CH     = CH_PER_BANK * NUM_BANKS,
    localparam int unsigned DATA_W     = 2 * CH_PER_BANK,
    localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W     = BANK_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0]     event_i,
    output logic [NUM_CH-1:0]     en_o,
    output logic [NUM_CH-1:0]     flag_o,
    output logic [2*NUM_CH-1:0]   mode_o,
    output logic [NUM_BANKS-1:0]  irq_o
);

    logic [BANK_W-1:0] bank_sel;
    logic [1:0]        reg_sel;

    assign bank_sel = bus_addr[ADDR_W-1:2];
    assign reg_sel  = bus_addr[1:0];

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic                   hit;
            logic [CH_PER_BANK-1:0] en_q;
            logic [CH_PER_BANK-1:0] flag_q;
            logic [DATA_W-1:0]      det_q;
            logic [CH_PER_BANK-1:0] clr_mask;

            assign hit      = bus_wr && (bank_sel == BANK_W'(b));
            assign clr_mask = (hit && reg_sel == REG_FLAG) ?
                              ~bus_wdata[CH_PER_BANK-1:0] : '0;

            // Enable and trigger-select registers, written whole.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q  <= '0;
                    det_q <= '0;
                end else begin
                    if (hit && reg_sel == REG_ENABLE) en_q  <= bus_wdata[CH_PER_BANK-1:0];
                    if (hit && reg_sel == REG_DETECT) det_q <= bus_wdata;
                end
            end

            // Sticky flags: zeros written clear, new events always win.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q <= '0;
                else        flag_q <= (flag_q & ~clr_mask) |
                                      event_i[b*CH_PER_BANK +: CH_PER_BANK];
            end

            assign en_o[b*CH_PER_BANK +: CH_PER_BANK]   = en_q;
            assign flag_o[b*CH_PER_BANK +: CH_PER_BANK] = flag_q;
            assign mode_o[b*DATA_W +: DATA_W]           = det_q;
            assign irq_o[b]                             = |(flag_q & en_q);
        end
    endgenerate

    // Combinational read mux over banks and register selects.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_sel == BANK_W'(i)) begin
                unique case (reg_sel)
                    REG_ENABLE: bus_rdata[CH_PER_BANK-1:0] = en_o[i*CH_PER_BANK +: CH_PER_BANK];
                    REG_FLAG:   bus_rdata[CH_PER_BANK-1:0] = flag_o[i*CH_PER_BANK +: CH_PER_BANK];
                    REG_DETECT: bus_rdata                  = mode_o[i*DATA_W +: DATA_W];
                    default:    bus_rdata                  = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ext_irq_bank.sv
// Top of the external interrupt detector: one filter and one trigger
// detector per channel feeding a shared register file that holds the
// enables, sticky flags and trigger codes and drives one line per bank.
// Assumes: pins are asynchronous; bus signals are synchronous to clk.
module ext_irq_bank #(
    parameter int unsigned CH_PER_BANK = 8,
    parameter int unsigned NUM_BANKS   = 2,
    parameter int unsigned FILT_LEN    = 3,
    localparam int unsigned NUM_CH     = CH_PER_BANK * NUM_BANKS,
    localparam int unsigned DATA_W     = 2 * CH_PER_BANK,
    localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W     = BANK_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    pin_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_BANKS-1:0] irq_out
);

    logic [NUM_CH-1:0]   filt;
    logic [NUM_CH-1:0]   filt_prev;
    logic [NUM_CH-1:0]   evt;
    logic [NUM_CH-1:0]   en_vec;
    logic [NUM_CH-1:0]   flag_vec;
    logic [2*NUM_CH-1:0] mode_vec;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            irq_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk         (clk),
                .rst_n       (rst_n),
                .pin_i       (pin_in[c]),
                .filt_o      (filt[c]),
                .filt_prev_o (filt_prev[c])
            );

            irq_trigger u_trig (
                .mode_i      (mode_vec[2*c +: 2]),
                .filt_i      (filt[c]),
                .filt_prev_i (filt_prev[c]),
                .event_o     (evt[c])
            );
        end
    endgenerate

    irq_regfile #(
        .CH_PER_BANK (CH_PER_BANK),
        .NUM_BANKS   (NUM_BANKS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .event_i   (evt),
        .en_o      (en_vec),
        .flag_o    (flag_vec),
        .mode_o    (mode_vec),
        .irq_o     (irq_out)
    );

endmodule

// File: rtl/ext_irq_bank_chk.sv
// Property checker for ext_irq_bank, attached by bind. Watches the flag,
// enable, event and trigger-code signals together with the bus and the
// interrupt lines.
// Assumes: the same parameters as the bound instance.
module ext_irq_bank_chk
    import extint_pkg::*;
#(
    parameter int unsigned CH_PER_BANK = 8,
    parameter int unsigned NUM_BANKS   = 2,
    localparam int unsigned NUM_CH     = CH_PER_BANK * NUM_BANKS,
    localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W     = BANK_W + 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [CH_PER_BANK-1:0] flag_wdata,
    input logic [NUM_BANKS-1:0]   irq_out,
    input logic [NUM_CH-1:0]      flag_vec,
    input logic [NUM_CH-1:0]      en_vec,
    input logic [NUM_CH-1:0]      evt,
    input logic [2*NUM_CH-1:0]    mode_vec
);

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_chan
            localparam int unsigned BANK = i / CH_PER_BANK;
            localparam int unsigned BITN = i % CH_PER_BANK;
            logic clr_hit;
            logic edge_mode;

            assign clr_hit   = bus_wr && bus_addr[ADDR_W-1:2] == BANK_W'(BANK) &&
                               bus_addr[1:0] == REG_FLAG && !flag_wdata[BITN];
            assign edge_mode = (mode_vec[2*i +: 2] == TRIG_RISE) ||
                               (mode_vec[2*i +: 2] == TRIG_FALL);

            // R6: a set flag holds unless its bit is written 0.
            p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_vec[i] && !clr_hit) |=> flag_vec[i]);

            // R6: a zero write with no event clears the flag.
            p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit && !evt[i]) |=> !flag_vec[i]);

            // R7: a flag never rises without an event (writing 1 sets nothing).
            p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_vec[i] && !evt[i]) |=> !flag_vec[i]);

            // R7: an event beats a clear in the same cycle.
            p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit && evt[i]) |=> flag_vec[i]);

            // R3: an edge trigger fires for one clock, never two in a row.
            p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && edge_mode) |=> !(evt[i] && edge_mode));
        end

        for (i = 0; i < NUM_BANKS; i++) begin : g_line
            // R8: a fully masked bank keeps its line low.
            p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (en_vec[i*CH_PER_BANK +: CH_PER_BANK] == '0) |-> !irq_out[i]);

            // R8: an enabled, flagged channel raises its bank's line.
            p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ((flag_vec[i*CH_PER_BANK +: CH_PER_BANK] &
                  en_vec[i*CH_PER_BANK +: CH_PER_BANK]) != '0) |-> irq_out[i]);
        end
    endgenerate

endmodule

bind ext_irq_bank ext_irq_bank_chk #(
    .CH_PER_BANK (CH_PER_BANK),
    .NUM_BANKS   (NUM_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .flag_wdata (bus_wdata[CH_PER_BANK-1:0]),
    .irq_out    (irq_out),
    .flag_vec   (flag_vec),
    .en_vec     (en_vec),
    .evt        (evt),
    .mode_vec   (mode_vec)
);

// File: tb/sim_ext_irq_bank.sv
// Self-checking bench: a vector table over trigger codes and banks, then
// directed tests for reset, register map, filter, clear rules and gating.
module sim_ext_irq_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pins;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [1:0]  shadow [16];
    logic [15:0] rd;

    // Table fields: [8:5] channel, [4:3] trigger code, [2] start, [1] end, [0] enable
    localparam logic [8:0] VEC [12] = '{
        {4'd0,  2'b10, 1'b0, 1'b1, 1'b1},
        {4'd1,  2'b10, 1'b1, 1'b0, 1'b1},
        {4'd2,  2'b11, 1'b1, 1'b0, 1'b0},
        {4'd3,  2'b11, 1'b0, 1'b1, 1'b1},
        {4'd4,  2'b01, 1'b0, 1'b1, 1'b1},
        {4'd5,  2'b01, 1'b0, 1'b0, 1'b1},
        {4'd6,  2'b00, 1'b1, 1'b0, 1'b0},
        {4'd7,  2'b00, 1'b1, 1'b1, 1'b1},
        {4'd8,  2'b10, 1'b0, 1'b1, 1'b1},
        {4'd11, 2'b11, 1'b1, 1'b0, 1'b1},
        {4'd13, 2'b01, 1'b1, 1'b0, 1'b1},
        {4'd15, 2'b00, 1'b0, 1'b1, 1'b1}
    };

    ext_irq_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [15:0] pack_detect(input int bank);
        logic [15:0] d;
        for (int i = 0; i < 8; i++) d[2*i +: 2] = shadow[bank*8 + i];
        return d;
    endfunction

    task automatic write_detect(input int bank);
        bus_write(3'(bank*4 + 2), pack_detect(bank));
    endtask

    function automatic logic exp_flag(input logic [1:0] m, input logic s, input logic e);
        case (m)
            2'b00:   return !s || !e;
            2'b01:   return s || e;
            2'b10:   return !s && e;
            default: return s && !e;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pins = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < 16; i++) shadow[i] = 2'b10;

        // R1: registers and lines are zero while reset is held.
        tick(3);
        foreach (VEC[k]) if (k < 6) begin
            bus_read(3'((k / 3) * 4 + (k % 3)), rd);
            check("R1 register in reset", rd, 16'h0000);
        end
        check("R1 irq in reset", 16'(irq_out), 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        write_detect(0);
        write_detect(1);

        // Table walk: R3/R4 flag per trigger code, R8 line gating.
        for (int v = 0; v < 12; v++) begin
            int ch, bk, bt;
            logic [1:0] m;
            logic s, e, en, ef;
            ch = int'(VEC[v][8:5]); m = VEC[v][4:3];
            s = VEC[v][2]; e = VEC[v][1]; en = VEC[v][0];
            bk = ch / 8; bt = ch % 8;
            ef = exp_flag(m, s, e);
            shadow[ch] = m;
            write_detect(bk);
            bus_write(3'(bk*4), en ? 16'(1 << bt) : 16'h0000);
            bus_write(3'((1-bk)*4), 16'h0000);
            @(negedge clk); pins[ch] = s;
            tick(12);
            bus_write(3'(bk*4 + 1), ~16'(1 << bt));
            pins[ch] = e;
            tick(12);
            bus_read(3'(bk*4 + 1), rd);
            check(m[1] ? "R3 edge flag" : "R4 level flag", 16'(rd[bt]), 16'(ef));
            check("R8 bank line", 16'(irq_out[bk]), 16'(ef && en));
            check("R8 other line", 16'(irq_out[1-bk]), 16'h0000);
        end

        // R2: register map and readback.
        bus_write(3'd6, 16'h1B6C);
        bus_read(3'd6, rd);
        check("R2 detect readback", rd, 16'h1B6C);
        write_detect(1);
        bus_read(3'd6, rd);
        check("R2 detect restore", rd, pack_detect(1));
        bus_read(3'd2, rd);
        check("R2 bank0 detect", rd, pack_detect(0));
        bus_write(3'd0, 16'hFF5A);
        bus_read(3'd0, rd);
        check("R2 enable upper bits zero", rd, 16'h005A);
        bus_read(3'd3, rd);
        check("R2 unmapped reads zero", rd, 16'h0000);
        bus_read(3'd7, rd);
        check("R2 unmapped bank1 reads zero", rd, 16'h0000);
        bus_write(3'd0, 16'h0000);

        // R5: filter rejects a 2-clock pulse and accepts a 3-clock one (ch9, rise).
        bus_write(3'd5, 16'h00FD);
        @(negedge clk); pins[9] = 1'b1;
        tick(2); pins[9] = 1'b0;
        tick(12);
        bus_read(3'd5, rd);
        check("R5 2-clock pulse ignored", 16'(rd[1]), 16'h0000);
        @(negedge clk); pins[9] = 1'b1;
        tick(3); pins[9] = 1'b0;
        tick(12);
        bus_read(3'd5, rd);
        check("R5 3-clock pulse detected", 16'(rd[1]), 16'h0001);
        bus_write(3'd5, 16'h00FD);
        @(negedge clk); pins[9] = 1'b1;
        tick(7);
        bus_read(3'd5, rd);
        check("R5 latency within 8 clocks", 16'(rd[1]), 16'h0001);
        pins[9] = 1'b0;
        tick(12);

        // R4/R7: clearing a level-triggered flag fails while the level holds (ch10).
        shadow[10] = 2'b01;
        write_detect(1);
        pins[10] = 1'b1;
        tick(12);
        bus_write(3'd5, 16'h00FB);
        bus_read(3'd5, rd);
        check("R4 level flag re-sets after clear", 16'(rd[2]), 16'h0001);
        pins[10] = 1'b0;
        tick(12);
        bus_write(3'd5, 16'h00FB);
        bus_read(3'd5, rd);
        check("R6 clear after level removed", 16'(rd[2]), 16'h0000);

        // R6/R7: clear all of bank1, then writing ones must set nothing.
        bus_write(3'd5, 16'h0000);
        bus_read(3'd5, rd);
        check("R6 bank1 cleared", rd, 16'h0000);
        bus_write(3'd5, 16'h00FF);
        bus_read(3'd5, rd);
        check("R7 write one no effect", rd, 16'h0000);

        // R8: masked channel still flags; enabling raises the line (ch12).
        bus_write(3'd4, 16'h0000);
        @(negedge clk); pins[12] = 1'b1;
        tick(12);
        bus_read(3'd5, rd);
        check("R8 flag set while masked", 16'(rd[4]), 16'h0001);
        check("R8 masked line low", 16'(irq_out[1]), 16'h0000);
        bus_write(3'd1, 16'h0000);
        tick(10);
        bus_read(3'd5, rd);
        check("R6 flag sticky across other-bank clear", 16'(rd[4]), 16'h0001);
        bus_write(3'd4, 16'h0010);
        #1;
        check("R8 line rises on enable", 16'(irq_out[1]), 16'h0001);
        check("R8 bank0 line stays low", 16'(irq_out[0]), 16'h0000);
        bus_write(3'd5, 16'h00EF);
        #1;
        check("R6 clear drops line", 16'(irq_out[1]), 16'h0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule